// File: doc/BRIEF.md
# Sliding Aperture Address Translator

This block lets a host reach an onboard memory that is larger than the host address window assigned to it. A single map register chooses the size of the window and which aligned slice of the memory the window currently shows. Each host request names a byte address inside the window and a length. The block returns the memory address of the first byte, reports how many window boundaries the request crosses, and marks as out of range any request that falls outside the window or runs past the end of the memory. To move the view, software rewrites the window offset.

The window size is a power of two of a base unit. The unit is 1 MB by default and is set by `UNIT_LOG2`. The size code in the map register is log2 of the size in units. Writes that ask for a window larger than the memory are clamped to the memory size. Writes whose code exceeds `MAX_CODE` (1 GB with the default unit) are refused as a whole. The translation is registered and appears one clock after the request.

Top module: `aperture_xlat`

## Requirements
- R1: After synchronous reset the map register reads as zero, and `xl_valid` and `xl_oob` are low. Both outputs are also low in any cycle that follows a cycle without `req_valid`.
- R2: A map write whose size code (bits [7:4]) is greater than `MAX_CODE` leaves the map register unchanged.
- R3: A size code above `MEM_LOG2` (window larger than memory) is stored as `MEM_LOG2`. The stored code never exceeds `MEM_LOG2`.
- R4: The stored window offset (bits [MEM_AW-1:UNIT_LOG2]) is aligned to the window size. Offset bits below the window size are cleared on write.
- R5: For an accepted request, `xl_valid` is high one cycle later. `xl_addr` then equals the window offset plus the request address masked with (window size − 1).
- R6: While the enable bit (bit 0) is clear, `xl_valid` and `xl_oob` stay low for every request.
- R7: An enabled request whose address is not below the window size gives `xl_oob` high and `xl_valid` low.
- R8: An enabled request whose last byte (offset + low address + `req_len_m1`) lies at or beyond the memory size gives `xl_oob` high, `xl_valid` low and no translation.
- R9: For an accepted request, `xl_span` equals (low address + `req_len_m1`) divided by the window size. This is the number of times the window must be advanced by one window size.
- R10: `xl_valid` and `xl_oob` are never high together. Both `xl_addr` and `xl_span` are zero whenever `xl_valid` is low.
- R11: A valid map write is visible on `cfg_rdata` after one clock edge. The value holds the enable bit in bit 0, the register-enable bit in bit 1 and zeros in all unused bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_wdata | input | REG_W | Map register write value |
| cfg_rdata | output | REG_W | Map register contents |
| req_valid | input | 1 | Host request present |
| req_addr | input | MEM_AW | Host byte address within the window |
| req_len_m1 | input | MEM_AW | Request length in bytes minus one |
| xl_valid | output | 1 | Translation accepted (registered) |
| xl_oob | output | 1 | Request outside window or memory (registered) |
| xl_addr | output | MEM_AW | Translated memory byte address |
| xl_span | output | MEM_LOG2+1 | Window boundaries crossed by the request |

## Verification
The bench sweeps every host address at every legal window size and every aligned window position of a 2 KB memory with 256-byte units. The request lengths are chosen so that requests land inside the window, cross one or more window edges, or run off the top of memory. A design that keeps an offset bit below the window size would return addresses in the wrong slice. A design that compares the last byte with the wrong bound would either accept a request that ends exactly past the memory or refuse one that ends on its last byte. A wrong shift for the span shows up as an off-by-one step count when a window edge is crossed. Directed writes check that an oversize code is clamped, an illegal code is refused, and a misaligned offset is trimmed; a block that got any of these wrong would show a different readback value.

// File: rtl/aperture_pkg.sv
package aperture_pkg;
  // Map register field positions; the size code position is decoded by software.
  localparam int EN_BIT     = 0;
  localparam int REGEN_BIT  = 1;
  localparam int CODE_LSB   = 4;
  localparam int CODE_W     = 4;
  localparam int OFFS_FLOOR = 8;  // lowest bit the window offset may occupy

  typedef logic [CODE_W-1:0] size_code_t;
endpackage

// File: rtl/aperture_map_reg.sv
module aperture_map_reg
  import aperture_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int UNIT_LOG2 = 20,
  parameter int MEM_LOG2  = 6,
  parameter int MAX_CODE  = 10,
  localparam int MEM_AW   = UNIT_LOG2 + MEM_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              en,
  output size_code_t        code,
  output logic [MEM_AW-1:0] base
);
  localparam size_code_t MEM_CODE = size_code_t'(MEM_LOG2);
  localparam size_code_t TOP_CODE = size_code_t'(MAX_CODE);

  logic [REG_W-1:0]  map_q;
  logic [REG_W-1:0]  map_d;
  size_code_t        wr_code;
  size_code_t        code_eff;
  logic              code_ok;
  logic [MEM_AW-1:0] offs_keep;

  assign wr_code  = wdata[CODE_LSB +: CODE_W];
  assign code_ok  = (wr_code <= TOP_CODE);
  assign code_eff = (wr_code > MEM_CODE) ? MEM_CODE : wr_code;

  // Offset bits at or above the clamped window size survive the write.
  for (genvar i = 0; i < MEM_AW; i++) begin : g_keep
    assign offs_keep[i] = (32'(i) >= 32'(UNIT_LOG2) + 32'(code_eff));
  end

  always_comb begin
    map_d = '0;
    map_d[MEM_AW-1:UNIT_LOG2] = wdata[MEM_AW-1:UNIT_LOG2] & offs_keep[MEM_AW-1:UNIT_LOG2];
    map_d[CODE_LSB +: CODE_W] = code_eff;
    map_d[REGEN_BIT]          = wdata[REGEN_BIT];
    map_d[EN_BIT]             = wdata[EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
    end else if (we && code_ok) begin
      map_q <= map_d;
    end
  end

  assign rdata = map_q;
  assign en    = map_q[EN_BIT];
  assign code  = map_q[CODE_LSB +: CODE_W];
  assign base  = {map_q[MEM_AW-1:UNIT_LOG2], {UNIT_LOG2{1'b0}}};

  // R2: an illegal size code leaves the register alone
  a_r2_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    (we && (wdata[CODE_LSB +: CODE_W] > TOP_CODE)) |=> $stable(rdata));

  // R3: the stored code never exceeds the memory size
  a_r3_code_clamped: assert property (@(posedge clk) disable iff (rst)
    rdata[CODE_LSB +: CODE_W] <= MEM_CODE);

  // R4: the stored offset is aligned to the window size
  a_r4_offs_aligned: assert property (@(posedge clk) disable iff (rst)
    (((MEM_AW+1)'(base)) & ((((MEM_AW+1)'(1)) << (UNIT_LOG2 + int'(code))) - 1)) == '0);
endmodule

// File: rtl/aperture_xlat_core.sv
module aperture_xlat_core
  import aperture_pkg::*;
#(
  parameter int UNIT_LOG2 = 20,
  parameter int MEM_LOG2  = 6,
  localparam int MEM_AW   = UNIT_LOG2 + MEM_LOG2,
  localparam int SPAN_W   = MEM_LOG2 + 1,
  localparam int EXT_W    = MEM_AW + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  size_code_t        code,
  input  logic [MEM_AW-1:0] base,
  input  logic              req_valid,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic [MEM_AW-1:0] req_len_m1,
  output logic              xl_valid,
  output logic              xl_oob,
  output logic [MEM_AW-1:0] xl_addr,
  output logic [SPAN_W-1:0] xl_span
);
  logic [5:0]        ap_sh;
  logic [MEM_AW-1:0] low_mask;
  logic [MEM_AW-1:0] low;
  logic              outside;
  logic [EXT_W-1:0]  last_byte;
  logic              beyond;
  logic [EXT_W-1:0]  rel_end;
  logic [EXT_W-1:0]  span_full;

  assign ap_sh = 6'(UNIT_LOG2) + 6'(code);

  for (genvar i = 0; i < MEM_AW; i++) begin : g_mask
    assign low_mask[i] = (6'(i) < ap_sh);
  end

  assign low       = req_addr & low_mask;
  assign outside   = |(req_addr & ~low_mask);
  assign last_byte = EXT_W'(base) + EXT_W'(low) + EXT_W'(req_len_m1);
  assign beyond    = |last_byte[EXT_W-1:MEM_AW];
  assign rel_end   = EXT_W'(low) + EXT_W'(req_len_m1);
  assign span_full = rel_end >> ap_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_valid <= 1'b0;
      xl_oob   <= 1'b0;
      xl_addr  <= '0;
      xl_span  <= '0;
    end else begin
      xl_valid <= 1'b0;
      xl_oob   <= 1'b0;
      xl_addr  <= '0;
      xl_span  <= '0;
      if (req_valid && en) begin
        if (outside || beyond) begin
          xl_oob <= 1'b1;
        end else begin
          xl_valid <= 1'b1;
          xl_addr  <= base | low;
          xl_span  <= span_full[SPAN_W-1:0];
        end
      end
    end
  end

  // R10: accepted and refused are exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(xl_valid && xl_oob));

  // R10: address and span are quiet when nothing was accepted
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !xl_valid |-> (xl_addr == '0 && xl_span == '0));

  // R6: disabled map register produces no result
  a_r6_disabled: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!xl_valid && !xl_oob));

  // R1: no request, no result
  a_r1_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> (!xl_valid && !xl_oob));

  // R5: a translated address lies inside the window that was mapped
  a_r5_in_window: assert property (@(posedge clk) disable iff (rst)
    xl_valid |-> (((xl_addr ^ $past(base)) >> (UNIT_LOG2 + int'($past(code)))) == '0));
endmodule

// File: rtl/aperture_xlat.sv
module aperture_xlat
  import aperture_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter int UNIT_LOG2 = 20,
  parameter int MEM_LOG2  = 6,
  parameter int MAX_CODE  = 10,
  localparam int MEM_AW   = UNIT_LOG2 + MEM_LOG2,
  localparam int SPAN_W   = MEM_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [MEM_AW-1:0] req_addr,
  input  logic [MEM_AW-1:0] req_len_m1,
  output logic              xl_valid,
  output logic              xl_oob,
  output logic [MEM_AW-1:0] xl_addr,
  output logic [SPAN_W-1:0] xl_span
);
  // The offset field must sit above the flag and code bits.
  logic              map_en;
  size_code_t        map_code;
  logic [MEM_AW-1:0] map_base;

  aperture_map_reg #(
    .REG_W(REG_W), .UNIT_LOG2(UNIT_LOG2), .MEM_LOG2(MEM_LOG2), .MAX_CODE(MAX_CODE)
  ) i_map (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .en(map_en), .code(map_code), .base(map_base)
  );

  aperture_xlat_core #(
    .UNIT_LOG2(UNIT_LOG2), .MEM_LOG2(MEM_LOG2)
  ) i_core (
    .clk(clk), .rst(rst), .en(map_en), .code(map_code), .base(map_base),
    .req_valid(req_valid), .req_addr(req_addr), .req_len_m1(req_len_m1),
    .xl_valid(xl_valid), .xl_oob(xl_oob), .xl_addr(xl_addr), .xl_span(xl_span)
  );

  initial begin
    if (UNIT_LOG2 < OFFS_FLOOR || MEM_AW > REG_W || MAX_CODE >= (1 << CODE_W))
      $display("aperture_xlat: parameter set out of range");
  end
endmodule

// File: tb/test_aperture_xlat.sv
module test_aperture_xlat;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W      = 32;
  localparam int UNIT_LOG2  = 8;
  localparam int MEM_LOG2   = 3;
  localparam int MAX_CODE   = 10;
  localparam int MEM_AW     = UNIT_LOG2 + MEM_LOG2;
  localparam int SPAN_W     = MEM_LOG2 + 1;
  localparam int MEM_BYTES  = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cfg_we = 1'b0;
  logic [REG_W-1:0]  cfg_wdata = '0;
  logic [REG_W-1:0]  cfg_rdata;
  logic              req_valid = 1'b0;
  logic [MEM_AW-1:0] req_addr = '0;
  logic [MEM_AW-1:0] req_len_m1 = '0;
  logic              xl_valid;
  logic              xl_oob;
  logic [MEM_AW-1:0] xl_addr;
  logic [SPAN_W-1:0] xl_span;

  int n_cmp = 0;
  int n_bad = 0;
  int mdl   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aperture_xlat #(
    .REG_W(REG_W), .UNIT_LOG2(UNIT_LOG2), .MEM_LOG2(MEM_LOG2), .MAX_CODE(MAX_CODE)
  ) i_aperture_xlat (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_len_m1(req_len_m1),
    .xl_valid(xl_valid), .xl_oob(xl_oob), .xl_addr(xl_addr), .xl_span(xl_span)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int pack_out(input int v, input int o, input int a, input int s);
    return (v << 31) | (o << 30) | (s << 16) | a;
  endfunction

  // Model of a map write, from R2/R3/R4/R11.
  task automatic cfg_write(input int wd);
    int c, ce, off;
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = REG_W'(wd);
    @(posedge clk);
    #1 cfg_we = 1'b0;
    c = (wd >> 4) & 15;
    if (c <= MAX_CODE) begin
      ce  = (c > MEM_LOG2) ? MEM_LOG2 : c;
      off = wd & (MEM_BYTES - 1) & ~((1 << (UNIT_LOG2 + ce)) - 1);
      mdl = off | (ce << 4) | (wd & 3);
    end
    chk("R11 map readback", int'(cfg_rdata), mdl);
  endtask

  task automatic do_req(input int a, input int len);
    int ce, ap, base, en, ev, eo, ea, es;
    string tag;
    @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = MEM_AW'(a);
    req_len_m1 = MEM_AW'(len);
    @(posedge clk);
    #1;
    ce = (mdl >> 4) & 15;
    ap = 1 << (UNIT_LOG2 + ce);
    base = mdl & (MEM_BYTES - 1) & ~(ap - 1);
    en = mdl & 1;
    ev = 0; eo = 0; ea = 0; es = 0;
    if (en == 0) begin
      tag = "R6 disabled";
    end else if (a >= ap) begin
      eo = 1; tag = "R7 outside window";
    end else if (base + a + len >= MEM_BYTES) begin
      eo = 1; tag = "R8 past memory end";
    end else begin
      ev = 1; ea = base + a; es = (a + len) / ap; tag = "R5 R9 R10 translate";
    end
    chk(tag, pack_out(int'(xl_valid), int'(xl_oob), int'(xl_addr), int'(xl_span)),
        pack_out(ev, eo, ea, es));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 reset map", int'(cfg_rdata), 0);
    chk("R1 reset outputs", int'({xl_valid, xl_oob}), 0);

    // R11, R4: misaligned offset trimmed, register-enable bit kept
    cfg_write('h300 | (1 << 4) | 3);
    chk("R4 trimmed offset", int'(cfg_rdata) & 'h700, 'h200);
    // R3: oversize code clamped, offset cleared
    cfg_write('h500 | (6 << 4) | 1);
    chk("R3 clamp code", (int'(cfg_rdata) >> 4) & 15, MEM_LOG2);
    // R2: illegal code refused
    cfg_write('h100 | (12 << 4) | 2);
    chk("R2 reject code", int'(cfg_rdata), 'h31);
    cfg_write('h100 | (15 << 4) | 0);
    chk("R2 reject code 15", int'(cfg_rdata), 'h31);
    // R3 at the top legal code
    cfg_write('h600 | (MAX_CODE << 4) | 1);
    chk("R3 clamp at max code", int'(cfg_rdata), 'h31);

    // R1: idle cycle gives no result
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1 chk("R1 idle", int'({xl_valid, xl_oob}), 0);

    // R6: disabled sweep
    cfg_write('h400 | (2 << 4) | 2);
    for (int a = 0; a < 256; a++) do_req(a * 8, a);

    // Sweep every legal size and window position
    for (int c = 0; c <= MEM_LOG2; c++) begin
      for (int w = 0; w < (1 << (MEM_LOG2 - c)); w++) begin
        cfg_write((w << (UNIT_LOG2 + c)) | (c << 4) | 1);
        for (int a = 0; a < MEM_BYTES; a++)
          do_req(a, (a % 3 == 0) ? ((a * 37) % MEM_BYTES) : ((a * 13) % 300));
      end
    end

    // R8 boundary: last byte exactly on, then one past, memory end
    cfg_write('h400 | (2 << 4) | 1);
    do_req('h3FF, 0);
    do_req('h0, 'h3FF);
    do_req('h1, 'h3FF);
    // R9: crossing exactly one window edge
    cfg_write((1 << 4) | 1);
    do_req('h1FF, 1);
    do_req('h1FF, 0);

    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1 chk("R1 idle after sweep", int'({xl_valid, xl_oob}), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule